// File: doc/BRIEF.md
# Per-Channel Multi-Event Hit Memory

This block buffers self-triggered hits for a bank of independent detector channels. Each time a channel fires, the block stores one event for it. An event is the current 12-bit time stamp, which arrives as an input, together with a 2-bit code. The code tells which of the channel's three discriminator thresholds were crossed. Every channel holds at most eight events.

A configuration bit sets what happens once a channel is full. In one mode the channel keeps its earliest events and ignores later hits. In the other mode the memory is circular: the newest hit replaces the oldest one, so the channel always holds its latest events.

Over the whole acquisition the block keeps a running total of triggers across all channels. If that total reaches a fixed limit, the acquisition is judged noisy. All stored data is then dropped, and nothing more is stored until the next clear.

The readout serializer selects a channel and an event index. It gets back that channel's event count and the selected event, combinationally. A single-cycle clear input starts a new acquisition.

Top module: `hitmem_top`

## Requirements
- R1: A synchronous reset, or an `acq_clear` pulse, sets every channel's event count to zero and lowers `noisy` at the next clock edge. A trigger presented in the same cycle as the clear is not stored and is not counted.
- R2: Channels store independently. When several channels trigger in the same cycle, each stores one event that carries that cycle's `tstamp`.
- R3: With `roll_mode`=0, a channel keeps its first 8 events. Any trigger that arrives while the channel holds 8 events changes neither its count nor its stored data.
- R4: A channel's three discriminator bits are stored as a 2-bit code, with the higher threshold taking priority. Bit 2 set gives 11. Otherwise bit 1 set gives 10. Otherwise bit 0 set gives 01. No bits set gives 00. Channel c's bits are `disc[3c+2:3c]`.
- R5: With `roll_mode`=1, a channel keeps its most recent 8 events, and the count saturates at 8. Read index 0 always returns the oldest event that is still held, and the indexes rise from oldest to newest.
- R6: `rd_count` is the event count of channel `rd_ch`. `rd_ts`/`rd_code` give event `rd_idx` of that channel. When `rd_idx` ≥ `rd_count`, both read as zero.
- R7: The block keeps a total of all trigger inputs since the last clear, across every channel, including triggers on full channels. The clock edge at which this total reaches 64 raises `noisy`, clears every channel's count, and stores none of that cycle's triggers. A total of 63 leaves everything unchanged.
- R8: While `noisy` is high, triggers are ignored. All counts stay zero and `noisy` stays high until a reset or a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acq_clear | input | 1 | Start-of-acquisition clear pulse |
| roll_mode | input | 1 | 0 = keep first events, 1 = circular keep last |
| trig | input | 64 | Per-channel trigger, one bit per channel |
| disc | input | 192 | Three discriminator bits per channel |
| tstamp | input | 12 | Current time stamp |
| rd_ch | input | 6 | Channel selected for readout |
| rd_idx | input | 3 | Event index within the selected channel |
| rd_count | output | 4 | Event count of the selected channel |
| rd_ts | output | 12 | Time stamp of the selected event |
| rd_code | output | 2 | Discriminator code of the selected event |
| noisy | output | 1 | Acquisition flagged as noisy |

## Verification
The hardest case to reach is the edge at which the chip-wide total first hits 64. Getting there takes dozens of triggers spread over many channels, and the block must not tip over one trigger early. The stimulus raises nine trigger bits at once for seven cycles, which brings the total to 63. It then reads back that all the data is still intact. After that it adds a single trigger on a fresh channel, and checks that this hit was dropped and that every count reads zero from then on. Keeping eight events at a wrapped read pointer in circular mode is reached by firing one channel eleven times. The read index is then swept across all eight slots.

// File: rtl/hitmem_pkg.sv
package hitmem_pkg;

    localparam int TS_W   = 12;
    localparam int CODE_W = 2;
    localparam int DISC_N = 3;

    typedef struct packed {
        logic [TS_W-1:0]   ts;
        logic [CODE_W-1:0] code;
    } hit_ev_t;

    // Highest crossed threshold wins.
    function automatic logic [CODE_W-1:0] disc_encode(input logic [DISC_N-1:0] d);
        if (d[2])      return 2'b11;
        else if (d[1]) return 2'b10;
        else if (d[0]) return 2'b01;
        else           return 2'b00;
    endfunction

endpackage

// File: rtl/hitmem_chan.sv
module hitmem_chan
    import hitmem_pkg::*;
#(
    parameter  int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                flush,
    input  logic                block,
    input  logic                roll_mode,
    input  logic                trig,
    input  logic [DISC_N-1:0]   disc,
    input  logic [TS_W-1:0]     tstamp,
    input  logic [PTR_W-1:0]    rd_idx,
    output logic [CNT_W-1:0]    cnt,
    output hit_ev_t             rd_ev
);

    hit_ev_t            mem [DEPTH];
    logic [CNT_W-1:0]   cnt_q;
    logic [PTR_W-1:0]   wp_q;
    logic               full;
    logic               wr_en;
    logic [PTR_W-1:0]   rd_phys;
    logic               in_range;

    assign full  = (cnt_q == CNT_W'(DEPTH));
    assign wr_en = trig && !block && !flush && (roll_mode || !full);

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            cnt_q <= '0;
            wp_q  <= '0;
        end else if (wr_en) begin
            wp_q <= wp_q + PTR_W'(1);
            if (!full) cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en && !rst) begin
            mem[wp_q] <= '{ts: tstamp, code: disc_encode(disc)};
        end
    end

    // Once wrapped, the oldest entry sits at the write pointer.
    assign rd_phys  = full ? (wp_q + rd_idx) : rd_idx;
    assign in_range = (CNT_W'(rd_idx) < cnt_q);
    assign rd_ev    = in_range ? mem[rd_phys] : '0;
    assign cnt      = cnt_q;

endmodule

// File: rtl/hitmem_noise.sv
module hitmem_noise #(
    parameter  int NCH   = 64,
    parameter  int LIMIT = 64,
    localparam int TOT_W = $clog2(LIMIT + NCH)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clr,
    input  logic [NCH-1:0]  trig,
    output logic            kill,
    output logic            noisy_q
);

    logic [TOT_W-1:0] total_q;
    logic [TOT_W-1:0] pop;
    logic [TOT_W-1:0] sum;

    always_comb begin
        pop = '0;
        for (int i = 0; i < NCH; i++) begin
            pop = pop + TOT_W'(trig[i]);
        end
    end

    assign sum  = total_q + pop;
    assign kill = !noisy_q && !clr && (sum >= TOT_W'(LIMIT));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            total_q <= '0;
            noisy_q <= 1'b0;
        end else if (kill) begin
            noisy_q <= 1'b1;
        end else if (!noisy_q) begin
            total_q <= sum;
        end
    end

endmodule

// File: rtl/hitmem_rdmux.sv
module hitmem_rdmux
    import hitmem_pkg::*;
#(
    parameter int NCH   = 64,
    parameter int CNT_W = 4,
    localparam int CH_W = $clog2(NCH)
) (
    input  logic [NCH-1:0][CNT_W-1:0] cnt_all,
    input  hit_ev_t [NCH-1:0]         ev_all,
    input  logic [CH_W-1:0]           rd_ch,
    output logic [CNT_W-1:0]          rd_count,
    output hit_ev_t                   rd_ev
);

    assign rd_count = cnt_all[rd_ch];
    assign rd_ev    = ev_all[rd_ch];

endmodule

// File: rtl/hitmem_top.sv
module hitmem_top
    import hitmem_pkg::*;
#(
    parameter  int NCH         = 64,
    parameter  int DEPTH       = 8,
    parameter  int NOISY_LIMIT = 64,
    localparam int CH_W        = $clog2(NCH),
    localparam int PTR_W       = $clog2(DEPTH),
    localparam int CNT_W       = $clog2(DEPTH + 1)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   acq_clear,
    input  logic                   roll_mode,
    input  logic [NCH-1:0]         trig,
    input  logic [DISC_N*NCH-1:0]  disc,
    input  logic [TS_W-1:0]        tstamp,
    input  logic [CH_W-1:0]        rd_ch,
    input  logic [PTR_W-1:0]       rd_idx,
    output logic [CNT_W-1:0]       rd_count,
    output logic [TS_W-1:0]        rd_ts,
    output logic [CODE_W-1:0]      rd_code,
    output logic                   noisy
);

    logic                      kill;
    logic                      noisy_q;
    logic                      flush;
    logic [NCH-1:0][CNT_W-1:0] cnt_all;
    hit_ev_t [NCH-1:0]         ev_all;
    hit_ev_t                   rd_ev;

    hitmem_noise #(.NCH(NCH), .LIMIT(NOISY_LIMIT)) u_noise (
        .clk     (clk),
        .rst     (rst),
        .clr     (acq_clear),
        .trig    (trig),
        .kill    (kill),
        .noisy_q (noisy_q)
    );

    assign flush = acq_clear || kill;

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        hitmem_chan #(.DEPTH(DEPTH)) u_chan (
            .clk       (clk),
            .rst       (rst),
            .flush     (flush),
            .block     (noisy_q),
            .roll_mode (roll_mode),
            .trig      (trig[c]),
            .disc      (disc[c*DISC_N +: DISC_N]),
            .tstamp    (tstamp),
            .rd_idx    (rd_idx),
            .cnt       (cnt_all[c]),
            .rd_ev     (ev_all[c])
        );
    end

    hitmem_rdmux #(.NCH(NCH), .CNT_W(CNT_W)) u_rdmux (
        .cnt_all  (cnt_all),
        .ev_all   (ev_all),
        .rd_ch    (rd_ch),
        .rd_count (rd_count),
        .rd_ev    (rd_ev)
    );

    assign rd_ts   = rd_ev.ts;
    assign rd_code = rd_ev.code;
    assign noisy   = noisy_q;

endmodule

// File: rtl/hitmem_chk.sv
module hitmem_chk #(
    parameter  int NCH   = 64,
    parameter  int DEPTH = 8,
    localparam int CH_W  = $clog2(NCH),
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             acq_clear,
    input logic             roll_mode,
    input logic [CH_W-1:0]  rd_ch,
    input logic [PTR_W-1:0] rd_idx,
    input logic [CNT_W-1:0] rd_count,
    input logic [11:0]      rd_ts,
    input logic [1:0]       rd_code,
    input logic             noisy
);

    // R1
    clear_empties_chk: assert property (@(posedge clk) disable iff (rst)
        acq_clear |=> (rd_count == '0 && !noisy));

    // R6
    count_bound_chk: assert property (@(posedge clk) disable iff (rst)
        rd_count <= CNT_W'(DEPTH));

    // R6
    out_of_range_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (CNT_W'(rd_idx) >= rd_count) |-> (rd_ts == '0 && rd_code == '0));

    // R2
    one_per_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (rd_ch != $past(rd_ch) || rd_count <= $past(rd_count) + CNT_W'(1)));

    // R3
    keep_first_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (!roll_mode && rd_count == CNT_W'(DEPTH) && !acq_clear && !noisy) |=>
        (noisy || roll_mode || rd_ch != $past(rd_ch) || rd_idx != $past(rd_idx) ||
         (rd_ts == $past(rd_ts) && rd_code == $past(rd_code))));

    // R5
    roll_stays_full_chk: assert property (@(posedge clk) disable iff (rst)
        (roll_mode && rd_count == CNT_W'(DEPTH) && !acq_clear && !noisy) |=>
        (noisy || rd_ch != $past(rd_ch) || rd_count == CNT_W'(DEPTH)));

    // R8
    noisy_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (noisy && !acq_clear) |=> noisy);

    // R7
    noisy_empty_chk: assert property (@(posedge clk) disable iff (rst)
        noisy |-> rd_count == '0);

endmodule

bind hitmem_top hitmem_chk #(.NCH(NCH), .DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .acq_clear (acq_clear),
    .roll_mode (roll_mode),
    .rd_ch     (rd_ch),
    .rd_idx    (rd_idx),
    .rd_count  (rd_count),
    .rd_ts     (rd_ts),
    .rd_code   (rd_code),
    .noisy     (noisy)
);

// File: tb/hitmem_top_tb_top.sv
module hitmem_top_tb_top;

    localparam int NCH = 64;
    localparam int DEPTH = 8;
    localparam int LIMIT = 64;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               acq_clear = 1'b0;
    logic               roll_mode = 1'b0;
    logic [NCH-1:0]     trig = '0;
    logic [3*NCH-1:0]   disc = '0;
    logic [11:0]        tstamp = '0;
    logic [5:0]         rd_ch = '0;
    logic [2:0]         rd_idx = '0;
    logic [3:0]         rd_count;
    logic [11:0]        rd_ts;
    logic [1:0]         rd_code;
    logic               noisy;

    int checks = 0;
    int errors = 0;

    // reference model
    logic [13:0] mq [NCH][$];
    bit          m_noisy = 1'b0;
    int          m_total = 0;

    always #10 clk = ~clk;

    hitmem_top dut_i (
        .clk(clk), .rst(rst), .acq_clear(acq_clear), .roll_mode(roll_mode),
        .trig(trig), .disc(disc), .tstamp(tstamp), .rd_ch(rd_ch),
        .rd_idx(rd_idx), .rd_count(rd_count), .rd_ts(rd_ts),
        .rd_code(rd_code), .noisy(noisy)
    );

    function automatic logic [1:0] ref_code(input logic [2:0] d);
        if (d[2]) return 2'd3;
        if (d[1]) return 2'd2;
        if (d[0]) return 2'd1;
        return 2'd0;
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int c = 0; c < NCH; c++) mq[c].delete();
    endtask

    // Called at a negedge: drive, compare, advance over one edge.
    task automatic step(input logic [NCH-1:0] t, input logic [3*NCH-1:0] d,
                        input logic clr, input int ch, input int idx, input string req);
        int sz;
        logic [13:0] ev;
        trig = t; disc = d; acq_clear = clr;
        rd_ch = 6'(ch); rd_idx = 3'(idx);
        #1;
        sz = mq[ch].size();
        ev = (idx < sz) ? mq[ch][idx] : 14'd0;
        chk(req, "rd_count", int'(rd_count), sz);
        chk(req, "rd_ts", int'(rd_ts), int'(ev[13:2]));
        chk(req, "rd_code", int'(rd_code), int'(ev[1:0]));
        chk(req, "noisy", int'(noisy), int'(m_noisy));
        @(posedge clk);
        if (clr) begin
            model_clear(); m_noisy = 0; m_total = 0;
        end else if (!m_noisy) begin
            m_total += $countones(t);
            if (m_total >= LIMIT) begin
                m_noisy = 1; model_clear();
            end else begin
                for (int c = 0; c < NCH; c++) begin
                    if (t[c]) begin
                        ev = {tstamp, ref_code(d[c*3 +: 3])};
                        if (roll_mode) begin
                            mq[c].push_back(ev);
                            if (mq[c].size() > DEPTH) void'(mq[c].pop_front());
                        end else if (mq[c].size() < DEPTH) begin
                            mq[c].push_back(ev);
                        end
                    end
                end
            end
        end
        @(negedge clk);
        tstamp = tstamp + 12'd37;
    endtask

    task automatic sweep(input int ch, input string req);
        for (int i = 0; i < DEPTH; i++) step('0, '0, 1'b0, ch, i, req);
    endtask

    task automatic fire(input int ch, input logic [2:0] d3, input string req);
        logic [NCH-1:0] t;
        logic [3*NCH-1:0] d;
        t = '0; d = '0;
        t[ch] = 1'b1; d[ch*3 +: 3] = d3;
        step(t, d, 1'b0, ch, 0, req);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [NCH-1:0] t;
        logic [3*NCH-1:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        step('0, '0, 1'b0, 0, 0, "R1");
        step('0, '0, 1'b0, 63, 3, "R1");

        // R2 simultaneous triggers on separate channels
        t = '0; d = '0;
        t[3] = 1; t[17] = 1; t[63] = 1;
        d[3*3 +: 3] = 3'b001; d[17*3 +: 3] = 3'b010; d[63*3 +: 3] = 3'b100;
        step(t, d, 1'b0, 3, 0, "R2");
        step('0, '0, 1'b0, 3, 0, "R2");
        step('0, '0, 1'b0, 17, 0, "R2");
        step('0, '0, 1'b0, 63, 0, "R2");
        // R6 indexes past the count read zero
        sweep(3, "R6");

        // R3 keep-first: ten hits, only first eight kept
        for (int k = 0; k < 10; k++) fire(5, 3'(k), "R3");
        sweep(5, "R3");

        // R4 every discriminator pattern
        for (int k = 0; k < 8; k++) fire(40, 3'(k), "R4");
        sweep(40, "R4");

        // R1 clear with a trigger in the same cycle
        t = '0; t[2] = 1;
        step(t, '0, 1'b1, 5, 0, "R1");
        step('0, '0, 1'b0, 2, 0, "R1");
        step('0, '0, 1'b0, 5, 0, "R1");

        // R5 circular mode
        roll_mode = 1'b1;
        for (int k = 0; k < 11; k++) fire(9, 3'(k + 1), "R5");
        sweep(9, "R5");
        for (int k = 0; k < 5; k++) fire(10, 3'(k), "R5");
        sweep(10, "R5");

        // R7 chip-wide total: 63 then 64
        step('0, '0, 1'b1, 0, 0, "R1");
        roll_mode = 1'b0;
        t = '0; d = '0;
        for (int c = 0; c < 9; c++) begin
            t[c] = 1'b1; d[c*3 +: 3] = 3'b011;
        end
        for (int k = 0; k < 7; k++) step(t, d, 1'b0, 0, k, "R7");
        sweep(0, "R7");
        step('0, '0, 1'b0, 8, 6, "R7");
        fire(20, 3'b111, "R7");
        step('0, '0, 1'b0, 20, 0, "R7");
        step('0, '0, 1'b0, 0, 0, "R7");

        // R8 triggers ignored while noisy
        for (int k = 0; k < 4; k++) step(t, d, 1'b0, k, 0, "R8");
        step('0, '0, 1'b0, 3, 0, "R8");
        step('0, '0, 1'b1, 3, 0, "R8");
        step('0, '0, 1'b0, 3, 0, "R1");
        fire(30, 3'b010, "R2");
        step('0, '0, 1'b0, 30, 0, "R2");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule